// File: doc/BRIEF.md
# Event Timer with Compare and Capture

This block is a general-purpose timer for a memory-mapped peripheral space. A free-running up counter advances once per clock while its count-enable bit is set. Two events are tracked against it: a compare event, raised when the counter steps onto the value in a compare register, and a capture event, raised when a selected edge arrives on an external input. On a capture event the current count is copied into a capture register. Each event latches a sticky flag in an 8-bit status register, and the flags are cleared by writing ones.

Software reaches the registers over a simple single-cycle bus. A write of any value to the counter address zeroes the counter. A single interrupt line to the system interrupt controller is raised by any flag whose enable bit is set in the mode register. It stays raised until software clears the flags behind it.

Register word addresses: 0 = mode, 1 = counter, 2 = compare, 3 = capture (read-only), 4 = status. Mode bits: bit 0 count enable, bit 1 compare interrupt enable, bit 2 capture interrupt enable, bit 3 capture edge select (0 = rising, 1 = falling). Status bits: bit 1 compare flag, bit 0 capture flag.

Top module: `evt_timer`

## Requirements
- R1: After reset the counter, compare, capture, mode and status registers all read zero, and `irq` is low.
- R2: While mode bit 0 is 1, the counter increases by one on every clock and wraps from 0xFFFF to 0x0000. While mode bit 0 is 0, the counter holds its value.
- R3: A write of any data to address 1 makes the counter read zero after that clock edge, and the write wins over an increment in the same cycle. Reading the counter does not change its counting.
- R4: Status bit 1 sets on the clock edge where the counter increments onto the compare value (address 2). Zeroing the counter by a write does not raise it.
- R5: `capIn` passes through a two-flop synchronizer. On the selected edge (mode bit 3: 0 rising, 1 falling), the capture register (address 3) loads the count, and status bit 0 sets on the same clock edge. The opposite edge has no effect. Writes to address 3 are ignored.
- R6: Event flags set whether or not their interrupt enable bits are set.
- R7: A write to address 4 clears each status bit whose data bit is 1 and leaves bits written with 0 unchanged. Both flags may be cleared in one write.
- R8: If an event occurs in the same cycle as a write that clears its flag, the flag stays set.
- R9: Status bits 7 to 2, mode bits above bit 3, and every address from 5 to 7 read as zero.
- R10: `irq` is high exactly when (status bit 1 and mode bit 1) or (status bit 0 and mode bit 2), and stays high until the enabled flags are cleared.
- R11: Mode bits 3 to 0 take the low four bits of a write to address 0 and read back unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Bus access select |
| busWr | input | 1 | Write when high, read when low |
| busAddr | input | 3 | Register word address |
| busWdata | input | CNT_W (16) | Write data |
| busRdata | output | CNT_W (16) | Read data of the addressed register, combinational |
| capIn | input | 1 | Asynchronous capture input |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bound checker checks these on every cycle:
- the counter's step, hold and clear behaviour;
- the compare flag rising when the counter steps onto the compare value;
- that flags stay set unless a clear write hits them;
- that `irq` is never raised without a flag behind it.

Only the bench's scenarios can show the rest:
- the capture path through the synchronizer under each edge selection, and the captured value;
- the set-over-clear collision;
- the wrap across 0xFFFF;
- that read-only and reserved locations ignore writes.

The bench's reference model covers all of these by comparing the read data and `irq` on every clock.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  localparam int ADDR_W = 3;
  localparam int MODE_W = 4;
  localparam int STAT_W = 8;

  localparam int MB_CNT_EN  = 0;
  localparam int MB_REF_IE  = 1;
  localparam int MB_CAP_IE  = 2;
  localparam int MB_CAP_FALL = 3;

  localparam int SB_CAP = 0;
  localparam int SB_REF = 1;

  typedef enum logic [ADDR_W-1:0] {
    ADR_MODE  = 3'd0,
    ADR_COUNT = 3'd1,
    ADR_REF   = 3'd2,
    ADR_CAPT  = 3'd3,
    ADR_STAT  = 3'd4
  } regAddr_e;

  typedef struct packed {
    logic       modeWr;
    logic       refWr;
    logic       cntClr;
    logic [1:0] flagClr;
    logic       capHit;
  } dpStrobe_t;
endpackage

// File: rtl/evt_timer_ctrl.sv
module evt_timer_ctrl
  import evt_timer_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        clrBits,
  input  logic              capIn,
  input  logic              capFalling,
  output dpStrobe_t         strobe
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic capPrev;
  logic capLevel;
  logic wrEn;

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[0] <= 1'b0;
          else       syncQ[0] <= capIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[g] <= 1'b0;
          else       syncQ[g] <= syncQ[g-1];
        end
      end
    end
  endgenerate

  assign capLevel = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) capPrev <= 1'b0;
    else       capPrev <= capLevel;
  end

  assign wrEn = busSel & busWr;

  always_comb begin
    strobe         = '0;
    strobe.modeWr  = wrEn && (busAddr == ADR_MODE);
    strobe.refWr   = wrEn && (busAddr == ADR_REF);
    strobe.cntClr  = wrEn && (busAddr == ADR_COUNT);
    strobe.flagClr = (wrEn && (busAddr == ADR_STAT)) ? clrBits : 2'b00;
    strobe.capHit  = capFalling ? (!capLevel && capPrev) : (capLevel && !capPrev);
  end
endmodule

// File: rtl/evt_timer_dp.sv
module evt_timer_dp
  import evt_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [CNT_W-1:0]  wdata,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [CNT_W-1:0]  rdData,
  output logic              irq,
  output logic              capFalling,
  output logic [CNT_W-1:0]  cntVal,
  output logic [CNT_W-1:0]  refVal,
  output logic [MODE_W-1:0] modeVal,
  output logic              refFlag,
  output logic              capFlag
);
  logic [CNT_W-1:0]  cntQ;
  logic [CNT_W-1:0]  refQ;
  logic [CNT_W-1:0]  capQ;
  logic [MODE_W-1:0] modeQ;
  logic              refFlagQ;
  logic              capFlagQ;
  logic              incr;
  logic [CNT_W-1:0]  cntNext;
  logic              refHit;
  logic [STAT_W-1:0] statusVec;

  assign incr    = modeQ[MB_CNT_EN] & ~strobe.cntClr;
  assign cntNext = cntQ + 1'b1;
  assign refHit  = incr && (cntNext == refQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cntQ <= '0;
    else if (strobe.cntClr) cntQ <= '0;
    else if (incr)          cntQ <= cntNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             refQ <= '0;
    else if (strobe.refWr) refQ <= wdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              modeQ <= '0;
    else if (strobe.modeWr) modeQ <= wdata[MODE_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              capQ <= '0;
    else if (strobe.capHit) capQ <= cntQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refFlagQ <= 1'b0;
      capFlagQ <= 1'b0;
    end else begin
      refFlagQ <= refHit        | (refFlagQ & ~strobe.flagClr[SB_REF]);
      capFlagQ <= strobe.capHit | (capFlagQ & ~strobe.flagClr[SB_CAP]);
    end
  end

  assign statusVec = {{(STAT_W-2){1'b0}}, refFlagQ, capFlagQ};

  always_comb begin
    case (rdAddr)
      ADR_MODE:  rdData = CNT_W'(modeQ);
      ADR_COUNT: rdData = cntQ;
      ADR_REF:   rdData = refQ;
      ADR_CAPT:  rdData = capQ;
      ADR_STAT:  rdData = CNT_W'(statusVec);
      default:   rdData = '0;
    endcase
  end

  assign irq = (refFlagQ & modeQ[MB_REF_IE]) | (capFlagQ & modeQ[MB_CAP_IE]);

  assign capFalling = modeQ[MB_CAP_FALL];
  assign cntVal     = cntQ;
  assign refVal     = refQ;
  assign modeVal    = modeQ;
  assign refFlag    = refFlagQ;
  assign capFlag    = capFlagQ;
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CNT_W-1:0]  busWdata,
  output logic [CNT_W-1:0]  busRdata,
  input  logic              capIn,
  output logic              irq
);
  dpStrobe_t         strobe;
  logic              capFalling;
  logic [CNT_W-1:0]  cntVal;
  logic [CNT_W-1:0]  refVal;
  logic [MODE_W-1:0] modeVal;
  logic              refFlag;
  logic              capFlag;

  evt_timer_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .busSel     (busSel),
    .busWr      (busWr),
    .busAddr    (busAddr),
    .clrBits    (busWdata[1:0]),
    .capIn      (capIn),
    .capFalling (capFalling),
    .strobe     (strobe)
  );

  evt_timer_dp #(.CNT_W(CNT_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .wdata      (busWdata),
    .rdAddr     (busAddr),
    .rdData     (busRdata),
    .irq        (irq),
    .capFalling (capFalling),
    .cntVal     (cntVal),
    .refVal     (refVal),
    .modeVal    (modeVal),
    .refFlag    (refFlag),
    .capFlag    (capFlag)
  );
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk
  import evt_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [CNT_W-1:0]  busWdata,
  input logic [CNT_W-1:0]  cntVal,
  input logic [CNT_W-1:0]  refVal,
  input logic [MODE_W-1:0] modeVal,
  input logic              refFlag,
  input logic              capFlag,
  input logic              irq
);
  logic cntWrite;
  logic statWrite;

  assign cntWrite  = busSel && busWr && (busAddr == 3'd1);
  assign statWrite = busSel && busWr && (busAddr == 3'd4);

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (modeVal[0] && !cntWrite) |=> (cntVal == $past(cntVal) + 1'b1));

  assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!modeVal[0] && !cntWrite) |=> $stable(cntVal));

  assert_count_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    cntWrite |=> (cntVal == '0));

  assert_ref_set_R4: assert property (@(posedge clk) disable iff (!rstN)
    (modeVal[0] && !cntWrite && (CNT_W'(cntVal + 1'b1) == refVal)) |=> refFlag);

  assert_ref_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    (refFlag && !(statWrite && busWdata[1])) |=> refFlag);

  assert_cap_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    (capFlag && !(statWrite && busWdata[0])) |=> capFlag);

  assert_irq_source_R10: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (refFlag || capFlag));
endmodule

bind evt_timer evt_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busSel   (busSel),
  .busWr    (busWr),
  .busAddr  (busAddr),
  .busWdata (busWdata),
  .cntVal   (cntVal),
  .refVal   (refVal),
  .modeVal  (modeVal),
  .refFlag  (refFlag),
  .capFlag  (capFlag),
  .irq      (irq)
);

// File: tb/evt_timer_bench.sv
`timescale 1ns/1ps
module evt_timer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [2:0]  busAddr = 3'd0;
  logic [15:0] busWdata = 16'd0;
  logic [15:0] busRdata;
  logic        capIn = 1'b0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  evt_timer u_evt_timer (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .capIn(capIn), .irq(irq)
  );

  // reference model state
  int mCnt, mRef, mCap, mMode, mRefF, mCapF, s0, s1, s2;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCnt = 0; mRef = 0; mCap = 0; mMode = 0; mRefF = 0; mCapF = 0;
      s0 = 0; s1 = 0; s2 = 0;
    end else begin
      bit wr, clrW, hit, edgeSeen;
      int nCnt, nCap, nMode, nRef, nRefF, nCapF;
      wr = busSel && busWr;
      clrW = wr && busAddr == 3'd1;
      hit = mMode[0] && !clrW && (((mCnt + 1) & 16'hFFFF) == mRef);
      edgeSeen = mMode[3] ? (s1 == 0 && s2 == 1) : (s1 == 1 && s2 == 0);
      nCnt = clrW ? 0 : (mMode[0] ? ((mCnt + 1) & 16'hFFFF) : mCnt);
      nMode = (wr && busAddr == 3'd0) ? (busWdata & 16'hF) : mMode;
      nRef = (wr && busAddr == 3'd2) ? int'(busWdata) : mRef;
      nCap = edgeSeen ? mCnt : mCap;
      nRefF = (hit || (mRefF && !(wr && busAddr == 3'd4 && busWdata[1]))) ? 1 : 0;
      nCapF = (edgeSeen || (mCapF && !(wr && busAddr == 3'd4 && busWdata[0]))) ? 1 : 0;
      s2 = s1; s1 = s0; s0 = int'(capIn);
      mCnt = nCnt; mMode = nMode; mRef = nRef; mCap = nCap;
      mRefF = nRefF; mCapF = nCapF;
    end
  end

  function automatic int modelRead(input logic [2:0] a);
    case (a)
      3'd0: return mMode;
      3'd1: return mCnt;
      3'd2: return mRef;
      3'd3: return mCap;
      3'd4: return mRefF * 2 + mCapF;
      default: return 0;
    endcase
  endfunction

  function automatic string tagFor(input logic [2:0] a);
    case (a)
      3'd0: return "R11";
      3'd1: return "R2";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always begin
    @(posedge clk);
    #1;
    if (rstN && !finished) begin
      chk(tagFor(busAddr), int'(busRdata), modelRead(busAddr));
      chk("R10", int'(irq), ((mRefF && mMode[1]) || (mCapF && mMode[2])) ? 1 : 0);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1;
    v = int'(busRdata);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int v, v2, held;
    idle(2);
    rstN = 1'b1;
    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      chk("R1", v, 0);
    end
    chk("R1", int'(irq), 0);

    // R11 mode write/readback, R2 hold while disabled
    wr(3'd0, 16'hFFF6);
    rd(3'd0, v);
    chk("R11", v, 6);
    idle(3);
    rd(3'd1, v);
    chk("R2", v, 0);

    // R9 unused addresses
    wr(3'd5, 16'h1234);
    rd(3'd5, v); chk("R9", v, 0);
    rd(3'd7, v); chk("R9", v, 0);

    // R2 counting by one per clock, R3 reads do not disturb it
    wr(3'd0, 16'h0001);
    idle(5);
    rd(3'd1, v);
    rd(3'd1, v2);
    chk("R2", v2, (v + 1) & 16'hFFFF);
    // R3 write while running: next read one clock later shows 1
    wr(3'd1, 16'hABCD);
    rd(3'd1, v);
    chk("R3", v, 1);
    // R3 write while stopped
    wr(3'd0, 16'h0000);
    wr(3'd1, 16'h5555);
    rd(3'd1, v);
    chk("R3", v, 0);

    // R4 and R6: compare flag with enables off
    wr(3'd2, 16'd5);
    wr(3'd0, 16'h0001);
    idle(8);
    rd(3'd4, v);
    chk("R4", v, 2);
    chk("R6", int'(irq), 0);
    // R10 enabling raises irq
    wr(3'd0, 16'h0003);
    #1;
    chk("R10", int'(irq), 1);
    // R7 zero bit does not clear, one bit clears
    wr(3'd4, 16'h0001);
    rd(3'd4, v);
    chk("R7", v, 2);
    chk("R10", int'(irq), 1);
    wr(3'd4, 16'h0002);
    rd(3'd4, v);
    chk("R7", v, 0);
    chk("R10", int'(irq), 0);

    // R5 rising-edge capture with counter stopped at a held value
    wr(3'd0, 16'h0000);
    rd(3'd1, held);
    capIn = 1'b1;
    idle(5);
    rd(3'd3, v);
    chk("R5", v, held);
    rd(3'd4, v);
    chk("R5", v, 1);
    // R5 capture register ignores writes
    wr(3'd3, 16'h1234);
    rd(3'd3, v);
    chk("R5", v, held);

    // R5 falling-edge select: rising edge ignored, falling edge captures
    wr(3'd0, 16'h0008);
    wr(3'd4, 16'h0003);
    capIn = 1'b0;
    idle(5);
    rd(3'd4, v);
    chk("R5", v, 1);
    wr(3'd4, 16'h0001);
    capIn = 1'b1;
    idle(5);
    rd(3'd4, v);
    chk("R5", v, 0);

    // R10 capture interrupt plus R9 reserved status bits with both flags set
    wr(3'd1, 16'h0000);
    wr(3'd2, 16'h0003);
    wr(3'd0, 16'h000D);
    capIn = 1'b0;
    idle(6);
    wr(3'd0, 16'h000C);
    rd(3'd4, v);
    chk("R9", v, 3);
    chk("R10", int'(irq), 1);
    wr(3'd4, 16'h0003);
    #1;
    chk("R10", int'(irq), 0);

    // R8 set wins over clear in the same cycle
    wr(3'd0, 16'h0000);
    wr(3'd1, 16'h0000);
    wr(3'd2, 16'h0002);
    wr(3'd0, 16'h0001);
    wr(3'd0, 16'h0000);
    rd(3'd4, v);
    chk("R4", v & 2, 2);
    wr(3'd1, 16'h0000);
    wr(3'd0, 16'h0001);
    wr(3'd4, 16'h0002);
    rd(3'd4, v);
    chk("R8", v & 2, 2);

    // R2 wrap across 0xFFFF
    wr(3'd0, 16'h0000);
    wr(3'd4, 16'h0003);
    wr(3'd1, 16'h0000);
    wr(3'd2, 16'hFFFF);
    wr(3'd0, 16'h0001);
    idle(65540);
    rd(3'd4, v);
    chk("R4", v, 2);
    rd(3'd1, v);
    chk("R2", (v < 16'h0100) ? 1 : 0, 1);

    idle(2);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 190000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule